// File: doc/BRIEF.md
# Special-Purpose Register File and Decoder

This block holds the special-purpose registers of a small RISC core and decodes the accesses made to them. A move-to write port composes a 16-bit register address by ORing a base value with an immediate. A move-from read port takes a ready-made address. Each address splits into a 5-bit group (bits 15:11) and an 11-bit index (bits 10:0). The block stores the machine state registers of group 0: version, next-PC, status, previous-PC, exception PC, effective address and exception status. It also stores way 0 of the data and instruction translation buffers, as a match array and a translate array for each.

Some writes have side effects. A status write that flips a translation-enable or supervisor bit raises a one-cycle full-flush pulse. Clearing the valid bit of a match entry raises a one-cycle page-invalidate pulse, which carries the page the entry held until then. The interrupt-controller and tick-timer registers are not stored here. Writes to them leave as strobes with data, and their read values come in on input ports. The translation-enable bits of the stored status drive two output levels that pick translated or pass-through addressing.

Top module: `sysreg_file`

## Requirements
- R1: A write targets address (mt_base | mt_imm). The group is address bits 15:11 and the index is bits 10:0.
- R2: Group 0 holds read/write registers at index 0 (version), 16, 17 (status), 18, 32, 48 and 64. A version read returns the stored value ANDed with 0xFFFF003F. Indices 1..4 read the constants 0x00000619, 0x00000020, 0x00000018 and 0x00000018, and writes to them are ignored.
- R3: Every status write stores the written data with bit 15 forced to 1.
- R4: `tlb_flush_all` is high for exactly the one cycle after a status write that changes bit 0 (supervisor), bit 5 (data translate) or bit 6 (instruction translate). It stays low for every other write.
- R5: `data_xlat_on` equals stored status bit 5 and `insn_xlat_on` equals stored status bit 6.
- R6: Groups 1 (data) and 2 (instruction) hold 128 match words at indices 512..639 and 128 translate words at indices 640..767. The entry number is the index minus the region base, and each word reads back as written.
- R7: A write of a match word with bit 0 clear pulses `page_inv` for one cycle after the write. `page_inv_addr` carries the entry's previous word with bits 12:0 cleared, and `page_inv_itlb` is 1 for group 2. The new word is then stored. A match write with bit 0 set raises no pulse.
- R8: Writes to indices 768..1535 of groups 1 and 2, and to any unmapped address, change no state and raise no pulse or strobe. Reads of them return 0.
- R9: A write to group 9 index 0 or 2, or to group 10 index 0 or 1, raises `irq_mask_we`, `irq_stat_we`, `tick_mode_we` or `tick_count_we` respectively for one cycle after the write, with the data on `ext_wdata`. Reads of these addresses return `irq_mask_rd`, `irq_stat_rd`, `tick_mode_rd` or `tick_count_rd`.
- R10: After reset the status reads 0x00008001, both translation outputs are low, the version reads 0x12000021 masked as in R2, and all other stored registers and buffer words read 0.
- R11: `mf_valid` is high in the cycle after `mf_en`. `mf_data` then holds the value addressed at that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mt_en | input | 1 | Move-to write request |
| mt_base | input | 16 | Base part of the write address |
| mt_imm | input | 16 | Immediate part of the write address |
| mt_data | input | 32 | Write data |
| mf_en | input | 1 | Move-from read request |
| mf_addr | input | 16 | Read address |
| mf_data | output | 32 | Read data, registered |
| mf_valid | output | 1 | Read data valid |
| tlb_flush_all | output | 1 | Full translation-buffer flush pulse |
| page_inv | output | 1 | Single-page invalidate pulse |
| page_inv_itlb | output | 1 | Invalidate targets the instruction buffer |
| page_inv_addr | output | 32 | Page address to invalidate |
| data_xlat_on | output | 1 | Data translation enabled |
| insn_xlat_on | output | 1 | Instruction translation enabled |
| irq_mask_we | output | 1 | Interrupt mask write strobe |
| irq_stat_we | output | 1 | Interrupt status write strobe |
| tick_mode_we | output | 1 | Timer mode write strobe |
| tick_count_we | output | 1 | Timer count write strobe |
| ext_wdata | output | 32 | Data for the forwarded writes |
| irq_mask_rd | input | 32 | Interrupt mask read value |
| irq_stat_rd | input | 32 | Interrupt status read value |
| tick_mode_rd | input | 32 | Timer mode read value |
| tick_count_rd | input | 32 | Timer count read value |

## Verification
The bench targets status writes that rewrite the same mode bits, writes that touch only bit 15 or other unrelated bits, and writes that flip one mode bit. A design that compared the whole word would flush where it should not, and one that compared too few bits would miss a flush. It clears match entries whose previous word had low bits set, and it clears entries at both ends of the array. A wrong page mask or a post-write value on the invalidate port shows up as a wrong address, and an off-by-one entry base shows up as a wrong address or a stray readback. It writes addresses split unevenly between base and immediate, and it writes to the inert way regions and the constant registers. A design that added the two parts, or that stored the inert writes somewhere, returns altered readback.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int DW      = 32;
  localparam int AW      = 16;
  localparam int IDX_W   = 11;
  localparam int GRP_W   = AW - IDX_W;

  // status bit positions
  localparam int SR_SM   = 0;
  localparam int SR_DME  = 5;
  localparam int SR_IME  = 6;
  localparam int SR_FO   = 15;
  localparam logic [DW-1:0] SR_MODE_MASK = (DW'(1) << SR_SM) | (DW'(1) << SR_DME) | (DW'(1) << SR_IME);
  localparam logic [DW-1:0] SR_FO_BIT    = DW'(1) << SR_FO;
  localparam logic [DW-1:0] SR_RESET     = SR_FO_BIT | (DW'(1) << SR_SM);

  localparam logic [DW-1:0] VER_RESET = 32'h1200_0021;
  localparam logic [DW-1:0] VER_MASK  = 32'hFFFF_003F;

  // translation buffer way-0 layout
  localparam int TLB_SETS   = 128;
  localparam int MATCH_BASE = 512;
  localparam int XLAT_BASE  = MATCH_BASE + TLB_SETS;
  localparam int INERT_LO   = XLAT_BASE + TLB_SETS;
  localparam int INERT_HI   = INERT_LO + 6 * TLB_SETS - 1;
  localparam int PAGE_BITS  = 13;

  typedef enum logic [3:0] {
    RG_NONE, RG_VER, RG_CFG, RG_NPC, RG_SR, RG_PPC, RG_EPC, RG_EEA,
    RG_ESR, RG_TLB_MATCH, RG_TLB_XLAT, RG_TLB_INERT,
    RG_PIC_MASK, RG_PIC_STAT, RG_TT_MODE, RG_TT_COUNT
  } region_e;

  typedef struct packed {
    region_e          region;
    logic             itlb;
    logic [IDX_W-1:0] idx;
  } dec_t;

  function automatic logic [AW-1:0] compose_addr(input logic [AW-1:0] base, input logic [AW-1:0] imm);
    return base | imm;
  endfunction

  function automatic logic [DW-1:0] page_base(input logic [DW-1:0] w);
    return w & ~((DW'(1) << PAGE_BITS) - DW'(1));
  endfunction

  function automatic logic [DW-1:0] cfg_word(input logic [2:0] n);
    case (n)
      3'd1:    return 32'h0000_0619;
      3'd2:    return 32'h0000_0020;
      3'd3:    return 32'h0000_0018;
      3'd4:    return 32'h0000_0018;
      default: return '0;
    endcase
  endfunction

  function automatic dec_t decode_addr(input logic [AW-1:0] a);
    dec_t d;
    logic [GRP_W-1:0] g;
    int i;
    g = a[AW-1 -: GRP_W];
    i = int'(a[IDX_W-1:0]);
    d.region = RG_NONE;
    d.itlb   = 1'b0;
    d.idx    = a[IDX_W-1:0];
    case (g)
      5'd0: begin
        if (i == 0)                d.region = RG_VER;
        else if (i >= 1 && i <= 4) d.region = RG_CFG;
        else if (i == 16)          d.region = RG_NPC;
        else if (i == 17)          d.region = RG_SR;
        else if (i == 18)          d.region = RG_PPC;
        else if (i == 32)          d.region = RG_EPC;
        else if (i == 48)          d.region = RG_EEA;
        else if (i == 64)          d.region = RG_ESR;
      end
      5'd1, 5'd2: begin
        d.itlb = (g == 5'd2);
        if (i >= MATCH_BASE && i < XLAT_BASE)     d.region = RG_TLB_MATCH;
        else if (i >= XLAT_BASE && i < INERT_LO)  d.region = RG_TLB_XLAT;
        else if (i >= INERT_LO && i <= INERT_HI)  d.region = RG_TLB_INERT;
      end
      5'd9: begin
        if (i == 0)      d.region = RG_PIC_MASK;
        else if (i == 2) d.region = RG_PIC_STAT;
      end
      5'd10: begin
        if (i == 0)      d.region = RG_TT_MODE;
        else if (i == 1) d.region = RG_TT_COUNT;
      end
      default: d.region = RG_NONE;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sysreg_addr_decode.sv
module sysreg_addr_decode
  import sysreg_pkg::*;
(
  input  logic [AW-1:0] addr,
  output dec_t          dec
);
  assign dec = decode_addr(addr);
endmodule

// File: rtl/sysreg_g0_regs.sv
module sysreg_g0_regs
  import sysreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  dec_t          wr_dec,
  input  logic [DW-1:0] wr_data,
  input  dec_t          rd_dec,
  output logic [DW-1:0] rd_word,
  output logic          flush_pulse,
  output logic          dmmu_on,
  output logic          immu_on
);
  logic [DW-1:0] ver_q, npc_q, sr_q, ppc_q, epc_q, eea_q, esr_q;
  logic          sr_write_evt;
  logic          mode_change_evt;

  assign sr_write_evt    = wr_fire && (wr_dec.region == RG_SR);
  assign mode_change_evt = sr_write_evt && (((sr_q ^ wr_data) & SR_MODE_MASK) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ver_q <= VER_RESET;
      npc_q <= '0;
      sr_q  <= SR_RESET;
      ppc_q <= '0;
      epc_q <= '0;
      eea_q <= '0;
      esr_q <= '0;
      flush_pulse <= 1'b0;
    end else begin
      flush_pulse <= mode_change_evt;
      if (wr_fire) begin
        case (wr_dec.region)
          RG_VER: ver_q <= wr_data;
          RG_NPC: npc_q <= wr_data;
          RG_SR:  sr_q  <= wr_data | SR_FO_BIT;
          RG_PPC: ppc_q <= wr_data;
          RG_EPC: epc_q <= wr_data;
          RG_EEA: eea_q <= wr_data;
          RG_ESR: esr_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign dmmu_on = sr_q[SR_DME];
  assign immu_on = sr_q[SR_IME];

  always_comb begin
    case (rd_dec.region)
      RG_VER:  rd_word = ver_q & VER_MASK;
      RG_CFG:  rd_word = cfg_word(rd_dec.idx[2:0]);
      RG_NPC:  rd_word = npc_q;
      RG_SR:   rd_word = sr_q;
      RG_PPC:  rd_word = ppc_q;
      RG_EPC:  rd_word = epc_q;
      RG_EEA:  rd_word = eea_q;
      RG_ESR:  rd_word = esr_q;
      default: rd_word = '0;
    endcase
  end

  assert_sr_fixed_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q[SR_FO]);
  assert_sr_write_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_write_evt |=> (sr_q == ($past(wr_data) | SR_FO_BIT)));
  assert_flush_means_mode_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> (((sr_q ^ $past(sr_q)) & SR_MODE_MASK) != '0));
  assert_mode_change_flushes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((sr_q ^ $past(sr_q)) & SR_MODE_MASK) != '0) |-> flush_pulse);
endmodule

// File: rtl/sysreg_tlb_way0.sv
module sysreg_tlb_way0
  import sysreg_pkg::*;
#(
  parameter int SETS  = TLB_SETS,
  parameter int MBASE = MATCH_BASE,
  parameter int XBASE = MATCH_BASE + TLB_SETS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_match,
  input  logic             we_xlat,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_match,
  output logic [DW-1:0]    rd_xlat,
  output logic             inv_q,
  output logic [DW-1:0]    inv_addr_q
);
  localparam int EW = $clog2(SETS);

  logic [DW-1:0] match_q [SETS];
  logic [DW-1:0] xlat_q  [SETS];

  logic [IDX_W-1:0] wm_off, wx_off, rm_off, rx_off;
  logic [EW-1:0]    wm_ent, wx_ent, rm_ent, rx_ent;
  logic             clear_evt;

  assign wm_off = wr_idx - IDX_W'(MBASE);
  assign wx_off = wr_idx - IDX_W'(XBASE);
  assign rm_off = rd_idx - IDX_W'(MBASE);
  assign rx_off = rd_idx - IDX_W'(XBASE);
  assign wm_ent = wm_off[EW-1:0];
  assign wx_ent = wx_off[EW-1:0];
  assign rm_ent = rm_off[EW-1:0];
  assign rx_ent = rx_off[EW-1:0];

  assign clear_evt = we_match && !wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SETS; k++) begin
        match_q[k] <= '0;
        xlat_q[k]  <= '0;
      end
      inv_q      <= 1'b0;
      inv_addr_q <= '0;
    end else begin
      inv_q      <= clear_evt;
      inv_addr_q <= clear_evt ? page_base(match_q[wm_ent]) : '0;
      if (we_match) match_q[wm_ent] <= wr_data;
      if (we_xlat)  xlat_q[wx_ent]  <= wr_data;
    end
  end

  assign rd_match = match_q[rm_ent];
  assign rd_xlat  = xlat_q[rx_ent];

  assert_inv_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q |-> ($past(we_match) && !$past(wr_data[0])));
  assert_valid_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_match && wr_data[0]) |=> !inv_q);
  assert_no_dual_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_match && we_xlat));
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
  import sysreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mt_en,
  input  logic [15:0] mt_base,
  input  logic [15:0] mt_imm,
  input  logic [31:0] mt_data,
  input  logic        mf_en,
  input  logic [15:0] mf_addr,
  output logic [31:0] mf_data,
  output logic        mf_valid,
  output logic        tlb_flush_all,
  output logic        page_inv,
  output logic        page_inv_itlb,
  output logic [31:0] page_inv_addr,
  output logic        data_xlat_on,
  output logic        insn_xlat_on,
  output logic        irq_mask_we,
  output logic        irq_stat_we,
  output logic        tick_mode_we,
  output logic        tick_count_we,
  output logic [31:0] ext_wdata,
  input  logic [31:0] irq_mask_rd,
  input  logic [31:0] irq_stat_rd,
  input  logic [31:0] tick_mode_rd,
  input  logic [31:0] tick_count_rd
);
  localparam int NTLB = 2;

  logic [AW-1:0] wr_addr;
  dec_t          wr_dec, rd_dec;
  logic [DW-1:0] g0_rd;
  logic [DW-1:0] rm [NTLB];
  logic [DW-1:0] rx [NTLB];
  logic [DW-1:0] inv_a [NTLB];
  logic [NTLB-1:0] inv_v;
  logic [DW-1:0] rd_word;
  logic          ext_evt;

  assign wr_addr = compose_addr(mt_base, mt_imm);

  sysreg_addr_decode u_wdec (.addr(wr_addr), .dec(wr_dec));
  sysreg_addr_decode u_rdec (.addr(mf_addr), .dec(rd_dec));

  sysreg_g0_regs u_g0 (
    .clk(clk), .rst_n(rst_n), .wr_fire(mt_en), .wr_dec(wr_dec), .wr_data(mt_data),
    .rd_dec(rd_dec), .rd_word(g0_rd), .flush_pulse(tlb_flush_all),
    .dmmu_on(data_xlat_on), .immu_on(insn_xlat_on)
  );

  for (genvar t = 0; t < NTLB; t++) begin : g_tlb
    sysreg_tlb_way0 u_tlb (
      .clk(clk), .rst_n(rst_n),
      .we_match(mt_en && wr_dec.region == RG_TLB_MATCH && wr_dec.itlb == 1'(t)),
      .we_xlat (mt_en && wr_dec.region == RG_TLB_XLAT  && wr_dec.itlb == 1'(t)),
      .wr_idx(wr_dec.idx), .wr_data(mt_data), .rd_idx(rd_dec.idx),
      .rd_match(rm[t]), .rd_xlat(rx[t]), .inv_q(inv_v[t]), .inv_addr_q(inv_a[t])
    );
  end

  assign page_inv      = |inv_v;
  assign page_inv_itlb = inv_v[1];
  assign page_inv_addr = inv_a[0] | inv_a[1];

  assign ext_evt = mt_en && (wr_dec.region inside {RG_PIC_MASK, RG_PIC_STAT, RG_TT_MODE, RG_TT_COUNT});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_mask_we   <= 1'b0;
      irq_stat_we   <= 1'b0;
      tick_mode_we  <= 1'b0;
      tick_count_we <= 1'b0;
      ext_wdata     <= '0;
    end else begin
      irq_mask_we   <= mt_en && wr_dec.region == RG_PIC_MASK;
      irq_stat_we   <= mt_en && wr_dec.region == RG_PIC_STAT;
      tick_mode_we  <= mt_en && wr_dec.region == RG_TT_MODE;
      tick_count_we <= mt_en && wr_dec.region == RG_TT_COUNT;
      if (ext_evt) ext_wdata <= mt_data;
    end
  end

  always_comb begin
    case (rd_dec.region)
      RG_TLB_MATCH: rd_word = rm[rd_dec.itlb];
      RG_TLB_XLAT:  rd_word = rx[rd_dec.itlb];
      RG_PIC_MASK:  rd_word = irq_mask_rd;
      RG_PIC_STAT:  rd_word = irq_stat_rd;
      RG_TT_MODE:   rd_word = tick_mode_rd;
      RG_TT_COUNT:  rd_word = tick_count_rd;
      default:      rd_word = g0_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mf_valid <= 1'b0;
      mf_data  <= '0;
    end else begin
      mf_valid <= mf_en;
      if (mf_en) mf_data <= rd_word;
    end
  end

  assert_ext_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_mask_we, irq_stat_we, tick_mode_we, tick_count_we}));
  assert_ext_strobe_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask_we || irq_stat_we || tick_mode_we || tick_count_we) |-> ($past(mt_en) && ext_wdata == $past(mt_data)));
  assert_single_invalidate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inv_v));
  assert_rd_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mf_en |=> mf_valid);
  assert_rd_valid_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mf_valid |-> $past(mf_en));
endmodule

// File: tb/sysreg_file_tb.sv
`timescale 1ns/1ps
module sysreg_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mt_en = 1'b0;
  logic [15:0] mt_base = '0, mt_imm = '0;
  logic [31:0] mt_data = '0;
  logic        mf_en = 1'b0;
  logic [15:0] mf_addr = '0;
  logic [31:0] mf_data;
  logic        mf_valid, tlb_flush_all, page_inv, page_inv_itlb;
  logic [31:0] page_inv_addr;
  logic        data_xlat_on, insn_xlat_on;
  logic        irq_mask_we, irq_stat_we, tick_mode_we, tick_count_we;
  logic [31:0] ext_wdata;
  logic [31:0] irq_mask_rd = 32'hA5A5_0001, irq_stat_rd = 32'h0000_00F2;
  logic [31:0] tick_mode_rd = 32'h6000_1234, tick_count_rd = 32'h0BAD_CAFE;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_ver, m_npc, m_sr, m_ppc, m_epc, m_eea, m_esr;
  logic [31:0] m_match [2][128];
  logic [31:0] m_xlat  [2][128];

  sysreg_file u_dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int g, input int i);
    return {g[4:0], i[10:0]};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [15:0] a);
    int g, i;
    g = int'(a[15:11]);
    i = int'(a[10:0]);
    if (g == 0) begin
      case (i)
        0:  return m_ver & 32'hFFFF_003F;
        1:  return 32'h0000_0619;
        2:  return 32'h0000_0020;
        3:  return 32'h0000_0018;
        4:  return 32'h0000_0018;
        16: return m_npc;
        17: return m_sr;
        18: return m_ppc;
        32: return m_epc;
        48: return m_eea;
        64: return m_esr;
        default: return 32'h0;
      endcase
    end
    if (g == 1 || g == 2) begin
      if (i >= 512 && i < 640) return m_match[g-1][i-512];
      if (i >= 640 && i < 768) return m_xlat[g-1][i-640];
      return 32'h0;
    end
    if (g == 9 && i == 0) return irq_mask_rd;
    if (g == 9 && i == 2) return irq_stat_rd;
    if (g == 10 && i == 0) return tick_mode_rd;
    if (g == 10 && i == 1) return tick_count_rd;
    return 32'h0;
  endfunction

  // starts and ends at a negative edge
  task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [15:0] split);
    int g, i;
    bit e_flush, e_inv;
    logic [31:0] e_page;
    logic [3:0] e_str;
    g = int'(a[15:11]);
    i = int'(a[10:0]);
    e_flush = (g == 0 && i == 17) && (((m_sr ^ d) & 32'h0000_0061) != 0);
    e_inv   = (g == 1 || g == 2) && i >= 512 && i < 640 && !d[0];
    e_page  = e_inv ? (m_match[g-1][i-512] & 32'hFFFF_E000) : 32'h0;
    e_str   = {g == 10 && i == 1, g == 10 && i == 0, g == 9 && i == 2, g == 9 && i == 0};
    mt_en = 1'b1; mt_data = d;
    mt_base = a & split;                       // R1: address split between base and immediate
    mt_imm  = a & (~split | 16'(($urandom % 2) ? a : 16'h0));
    @(posedge clk);
    @(negedge clk);
    mt_en = 1'b0;
    chk(tlb_flush_all == e_flush, "R4 flush pulse", 32'(tlb_flush_all), 32'(e_flush));
    chk(page_inv == e_inv, "R7 invalidate pulse", 32'(page_inv), 32'(e_inv));
    if (e_inv) begin
      chk(page_inv_addr == e_page, "R7 invalidate page", page_inv_addr, e_page);
      chk(page_inv_itlb == (g == 2), "R7 invalidate target", 32'(page_inv_itlb), 32'(g == 2));
    end
    chk({tick_count_we, tick_mode_we, irq_stat_we, irq_mask_we} == e_str, "R9/R8 strobes",
        32'({tick_count_we, tick_mode_we, irq_stat_we, irq_mask_we}), 32'(e_str));
    if (e_str != 0) chk(ext_wdata == d, "R9 forwarded data", ext_wdata, d);
    // model update
    if (g == 0) begin
      case (i)
        0:  m_ver = d;
        16: m_npc = d;
        17: m_sr  = d | 32'h0000_8000;
        18: m_ppc = d;
        32: m_epc = d;
        48: m_eea = d;
        64: m_esr = d;
        default: ;
      endcase
    end else if (g == 1 || g == 2) begin
      if (i >= 512 && i < 640) m_match[g-1][i-512] = d;
      else if (i >= 640 && i < 768) m_xlat[g-1][i-640] = d;
    end
    chk(data_xlat_on == m_sr[5], "R5 data translate level", 32'(data_xlat_on), 32'(m_sr[5]));
    chk(insn_xlat_on == m_sr[6], "R5 insn translate level", 32'(insn_xlat_on), 32'(m_sr[6]));
  endtask

  task automatic do_read(input logic [15:0] a, input string req);
    logic [31:0] e;
    e = exp_rd(a);
    mf_en = 1'b1; mf_addr = a;
    @(posedge clk);
    @(negedge clk);
    mf_en = 1'b0;
    chk(mf_valid == 1'b1, "R11 read valid", 32'(mf_valid), 32'h1);
    chk(mf_data == e, req, mf_data, e);
  endtask

  function automatic logic [15:0] rnd_addr();
    int c, g;
    c = int'($urandom % 8);
    g = 1 + int'($urandom % 2);
    case (c)
      0: begin
        int lst[12] = '{0, 1, 2, 3, 4, 16, 17, 18, 32, 48, 64, 5};
        return mk(0, lst[$urandom % 12]);
      end
      1, 2: return mk(g, 512 + (($urandom % 2) ? int'($urandom % 6) : 122 + int'($urandom % 6)));
      3: return mk(g, 640 + int'($urandom % 6));
      4: return mk(g, 768 + int'($urandom % 768));    // R8 inert ways
      5: return ($urandom % 2) ? mk(3 + int'($urandom % 6), int'($urandom % 2048)) : mk(g, int'($urandom % 512));
      6: begin
        int ex[5][2] = '{'{9, 0}, '{9, 2}, '{10, 0}, '{10, 1}, '{9, 1}};
        int k = int'($urandom % 5);
        return mk(ex[k][0], ex[k][1]);
      end
      default: return mk(0, 17);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_ver = 32'h1200_0021; m_npc = 0; m_sr = 32'h0000_8001;
    m_ppc = 0; m_epc = 0; m_eea = 0; m_esr = 0;
    for (int t = 0; t < 2; t++)
      for (int k = 0; k < 128; k++) begin m_match[t][k] = 0; m_xlat[t][k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(data_xlat_on == 0 && insn_xlat_on == 0, "R10 translation off at reset",
        32'({data_xlat_on, insn_xlat_on}), 32'h0);
    chk(tlb_flush_all == 0 && page_inv == 0, "R10 no pulses at reset",
        32'({tlb_flush_all, page_inv}), 32'h0);
    do_read(mk(0, 17), "R10 status reset");
    do_read(mk(0, 0),  "R10 version reset masked");
    do_read(mk(1, 512), "R10 data match reset");
    do_read(mk(2, 767), "R10 insn translate reset");
    do_read(mk(0, 16), "R10 next-pc reset");

    // R2 constants and masked version
    do_write(mk(0, 2), 32'hFFFF_FFFF, 16'hFFFF);
    do_read(mk(0, 2), "R2 config write ignored");
    do_read(mk(0, 4), "R2 config constant");
    do_write(mk(0, 0), 32'hDEAD_BEEF, 16'hF800);
    do_read(mk(0, 0), "R2 version masked");

    // R3/R4/R5 status writes
    do_write(mk(0, 17), 32'h0000_0001, 16'h0000);   // same mode bits, FO cleared in data
    do_read(mk(0, 17), "R3 fixed-one forced");
    do_write(mk(0, 17), 32'h0000_0021, 16'h07FF);   // data translate on
    do_write(mk(0, 17), 32'hFFFF_FF9E, 16'hAAAA);   // unrelated bits only change? no: SM cleared
    do_write(mk(0, 17), 32'h0000_0040, 16'h0000);   // insn translate on, data off
    do_write(mk(0, 17), 32'h1234_0040, 16'h5555);   // no mode change

    // R6/R7 boundary entries and invalidate
    do_write(mk(1, 639), 32'h1234_5FFF, 16'hF800);
    do_write(mk(1, 639), 32'h0000_0000, 16'h0000);  // expect page 0x12344000
    do_read(mk(1, 639), "R6 match entry 127 updated");
    do_write(mk(2, 512), 32'hFFFF_FFFF, 16'h00FF);
    do_write(mk(2, 512), 32'h0000_0003, 16'h00FF);  // bit0 set: no pulse
    do_write(mk(2, 512), 32'h0000_1000, 16'h0F0F);  // expect page 0x00000000
    do_write(mk(2, 767), 32'hCAFE_F00D, 16'hF000);
    do_read(mk(2, 767), "R6 translate entry 127");
    do_write(mk(1, 640), 32'h0101_0101, 16'h0000);
    do_read(mk(1, 640), "R6 translate entry 0");
    do_read(mk(2, 640), "R6 instruction buffer unaffected");

    // R8 inert and unmapped
    do_write(mk(1, 768), 32'hFFFF_FFFE, 16'hFFFF);
    do_write(mk(2, 1535), 32'h0, 16'h0000);
    do_read(mk(1, 768), "R8 inert read zero");
    do_read(mk(2, 1535), "R8 inert read zero");
    do_write(mk(1, 1536), 32'h5555_5555, 16'h0000);
    do_read(mk(1, 1536), "R8 unmapped read zero");
    do_read(mk(1, 512), "R8 match entry 0 untouched");

    // R9 forwarded registers
    do_write(mk(9, 0), 32'h0000_00FF, 16'hF800);
    do_write(mk(10, 1), 32'h0000_0777, 16'h0000);
    do_read(mk(9, 2), "R9 interrupt status readback");
    do_read(mk(10, 0), "R9 timer mode readback");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [31:0] d;
      a = rnd_addr();
      d = $urandom;
      if ($urandom % 3 == 0) d[0] = 1'b0;
      if ($urandom % 2) do_write(a, d, 16'($urandom));
      else do_read(a, "R1/R2/R6 random readback");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule